// File: doc/BRIEF.md
# Self-Timed Dual-Rail Ring Counter

This block is a free-running counter that has no count enable and no input data. Its state is one data token that travels around a closed ring of three dual-rail handshake stages. One stage is an output stage that feeds both the consumer and the next stage. One stage is pre-loaded at reset with the value zero. The third stage sits in front of a dual-rail incrementer. Each time the token passes through the incrementer it gains one. Each time the consumer completes a four-phase handshake on the output boundary, the ring releases the next value.

Each stage is a row of hysteresis cells that follow the usual null-convention rules. A rail sets when its input and the stage enable are both asserted. It clears when both are deasserted. In every other case it holds. Each stage keeps its own completion flag. That flag goes to data once every bit has one rail set, and goes back to null once every rail is clear. The stage behind it uses the inverted flag as its enable. In this code base the cells are evaluated on a clock, so each hop through a stage takes one cycle. No stage is ever advanced by the clock alone.

The consumer side works as follows. The output is a pair of W-bit vectors, one for the true rail and one for the false rail. A single acknowledge comes back from the consumer. The consumer raises the acknowledge after it has taken a complete token. It lowers the acknowledge after it has seen the output return to all-null.

Top module: `srtc_counter`

## Requirements
- R1: While reset is held and right after it, both output rail vectors are all zero (the null state). The output stays null until the ring delivers its first token.
- R2: Every delivered token is dual-rail legal. For each bit, exactly one of `cnt_t[i]` (value 1) and `cnt_f[i]` (value 0) is set. The encoded value is `cnt_t`.
- R3: The first token after reset carries the pre-loaded value plus one. With the default pre-load of 0, that value is 1.
- R4: Each token equals the previous token plus one, modulo 2^W. From all-ones the count wraps to zero, and no carry-out exists.
- R5: After the consumer raises `cnt_ack`, the output goes fully null before any other data value appears. A null therefore separates every pair of tokens.
- R6: A complete token stays unchanged on the output for as long as `cnt_ack` stays low, however long the consumer waits.
- R7: While `cnt_ack` stays high, the output stays null. No new token appears until the consumer has lowered the acknowledge.
- R8: Every value that leaves the incrementer is complete exactly when its input stage is complete, and is that stage's value plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Evaluation clock for the hysteresis cells |
| rst_n | input | 1 | Active-low reset; loads the ring's initial token |
| cnt_t | output | W | True rail of the count, one bit per count bit |
| cnt_f | output | W | False rail of the count, one bit per count bit |
| cnt_ack | input | 1 | Consumer completion: high after a token is taken, low after null is seen |

## Verification
The bench builds the counter with its default width of 8 and a pre-load of zero. At that size, 259 transfers complete a full lap through all 256 values and cross the all-ones to zero wrap. This shows that the top half-adder cell drops its carry instead of corrupting the count. The bench also holds the acknowledge in each phase for tens of cycles, which brings the long-wait corners of both handshake phases into view. Random consumer delays shift the acknowledge against the ring's own timing, so the join between the consumer and the ring stage is reached in both possible orders.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

    // Completion state of a dual-rail stage.
    typedef enum logic {
        DR_NULL = 1'b0,
        DR_DATA = 1'b1
    } dr_phase_e;

endpackage

// File: rtl/srtc_link.sv
module srtc_link
    import srtc_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter bit          INIT_DATA = 1'b0,
    parameter logic [W-1:0] INIT_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_t,
    input  logic [W-1:0] in_f,
    input  logic         en,
    output logic [W-1:0] out_t,
    output logic [W-1:0] out_f,
    output logic         comp
);

    localparam logic [W-1:0] RST_T = INIT_DATA ? INIT_VAL  : '0;
    localparam logic [W-1:0] RST_F = INIT_DATA ? ~INIT_VAL : '0;
    localparam dr_phase_e    RST_C = INIT_DATA ? DR_DATA   : DR_NULL;

    typedef struct packed {
        logic [W-1:0] t;
        logic [W-1:0] f;
        dr_phase_e    ph;
    } link_state_t;

    link_state_t st_d, st_q;
    logic [W-1:0] any_rail_d;

    // Hysteresis cells: set on (in & en), clear on (!in & !en), else hold.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            st_d.t[i] = (in_t[i] & en) | (st_q.t[i] & (in_t[i] | en));
            st_d.f[i] = (in_f[i] & en) | (st_q.f[i] & (in_f[i] | en));
        end
        any_rail_d = st_d.t | st_d.f;
        if (&any_rail_d) begin
            st_d.ph = DR_DATA;
        end else if (~|any_rail_d) begin
            st_d.ph = DR_NULL;
        end else begin
            st_d.ph = st_q.ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.t  <= RST_T;
            st_q.f  <= RST_F;
            st_q.ph <= RST_C;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_t = st_q.t;
    assign out_f = st_q.f;
    assign comp  = (st_q.ph == DR_DATA);

    // R2: no bit ever carries both rails at once
    a_r2_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ~|(st_q.t & st_q.f));

    // R2: a data-phase flag means every bit holds a rail
    a_r2_comp_means_full: assert property (@(posedge clk) disable iff (!rst_n)
        comp |-> &(st_q.t | st_q.f));

    // R5: a complete token never turns into another token without a null between
    a_r5_data_via_null: assert property (@(posedge clk) disable iff (!rst_n)
        (&(st_q.t | st_q.f)) |=> (~|(st_q.t | st_q.f)) || ($stable(st_q.t) && $stable(st_q.f)));

endmodule

// File: rtl/srtc_half_add.sv
module srtc_half_add (
    input  logic a_t,
    input  logic a_f,
    input  logic c_t,
    input  logic c_f,
    output logic s_t,
    output logic s_f,
    output logic co_t,
    output logic co_f
);

    // Each output rail needs one rail from each input, so the outputs stay null
    // until both inputs are complete.
    always_comb begin
        s_f  = (a_f & c_f) | (a_t & c_t);
        s_t  = (a_f & c_t) | (a_t & c_f);
        co_t = a_t & c_t;
        co_f = (a_f & c_f) | (a_f & c_t) | (a_t & c_f);
    end

endmodule

// File: rtl/srtc_incr.sv
module srtc_incr #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_t,
    input  logic [W-1:0] a_f,
    output logic [W-1:0] s_t,
    output logic [W-1:0] s_f
);

    // Carry into bit i, as two rails; index 0 is unused.
    logic [W:0] cy_t;
    logic [W:0] cy_f;
    logic [W-1:0] drop_t;
    logic [W-1:0] drop_f;

    // Bit 0 adds the constant one: a false bit becomes true with no carry,
    // and a true bit becomes false with a carry.
    always_comb begin
        s_t[0]  = a_f[0];
        s_f[0]  = a_t[0];
        cy_t[0] = 1'b0;
        cy_f[0] = 1'b0;
        cy_t[1] = a_t[0];
        cy_f[1] = a_f[0];
    end

    assign drop_t[0] = 1'b0;
    assign drop_f[0] = 1'b0;

    generate
        for (genvar g = 1; g < W; g++) begin : g_cell
            logic co_t_w;
            logic co_f_w;
            srtc_half_add u_ha (
                .a_t  (a_t[g]),
                .a_f  (a_f[g]),
                .c_t  (cy_t[g]),
                .c_f  (cy_f[g]),
                .s_t  (s_t[g]),
                .s_f  (s_f[g]),
                .co_t (co_t_w),
                .co_f (co_f_w)
            );
            assign cy_t[g+1]  = co_t_w;
            assign cy_f[g+1]  = co_f_w;
            assign drop_t[g]  = co_t_w;
            assign drop_f[g]  = co_f_w;
        end
    endgenerate

endmodule

// File: rtl/srtc_counter.sv
module srtc_counter
    import srtc_pkg::*;
#(
    parameter int unsigned W          = 8,
    parameter int unsigned INIT_COUNT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_t,
    output logic [W-1:0] cnt_f,
    input  logic         cnt_ack
);

    localparam logic [W-1:0] PRELOAD = W'(INIT_COUNT);

    // Ring: incrementer -> out stage -> hold stage (pre-loaded) -> feed stage -> incrementer
    logic [W-1:0] out_t, out_f;
    logic [W-1:0] hold_t, hold_f;
    logic [W-1:0] feed_t, feed_f;
    logic [W-1:0] inc_t, inc_f;
    logic         out_comp, hold_comp, feed_comp;
    logic         out_en, hold_en, feed_en;

    // Join of the two receivers of the out stage (hysteresis cell).
    typedef struct packed {
        dr_phase_e join_ph;
    } join_state_t;

    join_state_t js_d, js_q;

    always_comb begin
        js_d = js_q;
        if (hold_comp && cnt_ack) begin
            js_d.join_ph = DR_DATA;
        end else if (!hold_comp && !cnt_ack) begin
            js_d.join_ph = DR_NULL;
        end
    end

    // The hold stage starts with data, so the join starts in the data phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            js_q.join_ph <= DR_DATA;
        end else begin
            js_q <= js_d;
        end
    end

    assign out_en  = (js_q.join_ph == DR_NULL);
    assign hold_en = !feed_comp;
    assign feed_en = !out_comp;

    srtc_link #(.W(W), .INIT_DATA(1'b0), .INIT_VAL('0)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .in_t  (inc_t),
        .in_f  (inc_f),
        .en    (out_en),
        .out_t (out_t),
        .out_f (out_f),
        .comp  (out_comp)
    );

    srtc_link #(.W(W), .INIT_DATA(1'b1), .INIT_VAL(PRELOAD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .in_t  (out_t),
        .in_f  (out_f),
        .en    (hold_en),
        .out_t (hold_t),
        .out_f (hold_f),
        .comp  (hold_comp)
    );

    srtc_link #(.W(W), .INIT_DATA(1'b0), .INIT_VAL('0)) u_feed (
        .clk   (clk),
        .rst_n (rst_n),
        .in_t  (hold_t),
        .in_f  (hold_f),
        .en    (feed_en),
        .out_t (feed_t),
        .out_f (feed_f),
        .comp  (feed_comp)
    );

    srtc_incr #(.W(W)) u_inc (
        .a_t (feed_t),
        .a_f (feed_f),
        .s_t (inc_t),
        .s_f (inc_f)
    );

    assign cnt_t = out_t;
    assign cnt_f = out_f;

    // R6: a complete token is held while the consumer has not acknowledged
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((&(cnt_t | cnt_f)) && !cnt_ack) |=> ($stable(cnt_t) && $stable(cnt_f)));

    // R7: the output stays null while the acknowledge is high
    a_r7_null_while_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((~|(cnt_t | cnt_f)) && cnt_ack) |=> (~|(cnt_t | cnt_f)));

    // R8: incrementer output is complete exactly when its input stage is
    a_r8_inc_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (&(feed_t | feed_f)) == (&(inc_t | inc_f)));

    // R8: incrementer output value is the input value plus one
    a_r8_inc_value: assert property (@(posedge clk) disable iff (!rst_n)
        (&(feed_t | feed_f)) |-> (inc_t == W'(feed_t + 1'b1)));

    // R4: the out stage captures only the incremented feed value
    a_r4_capture_is_next: assert property (@(posedge clk) disable iff (!rst_n)
        ((~|(out_t | out_f)) ##1 (&(out_t | out_f))) |-> (out_t == W'($past(feed_t) + 1'b1)));

endmodule

// File: tb/srtc_counter_tb.sv
module srtc_counter_tb_top;

    localparam int unsigned W        = 8;
    localparam int unsigned WAIT_MAX = 1000;
    localparam logic [W-1:0] ALL1    = '1;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] cnt_t;
    logic [W-1:0] cnt_f;
    logic         cnt_ack;

    int unsigned n_checks;
    int unsigned n_fail;
    logic [W-1:0] expect_next;

    srtc_counter #(.W(W), .INIT_COUNT(0)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_t   (cnt_t),
        .cnt_f   (cnt_f),
        .cnt_ack (cnt_ack)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_full(input logic [W-1:0] t, input logic [W-1:0] f);
        return &(t | f);
    endfunction

    function automatic bit is_null(input logic [W-1:0] t, input logic [W-1:0] f);
        return ~|(t | f);
    endfunction

    // Wait for a complete token, check it (R2, R4), hold it for hold_n cycles (R6),
    // acknowledge, wait for null (R5), keep ack high for gap_n cycles (R7), release.
    task automatic take_token(input int unsigned hold_n, input int unsigned gap_n,
                              input string req_val);
        logic [W-1:0] tok;
        int unsigned  w;
        w = 0;
        while (!is_full(cnt_t, cnt_f) && w < WAIT_MAX) begin
            @(negedge clk);
            w++;
        end
        check(w < WAIT_MAX, "R4 token arrives", cnt_t, expect_next);
        tok = cnt_t;
        check(((cnt_t ^ cnt_f) == ALL1) && ((cnt_t & cnt_f) == '0), "R2 legal token",
              cnt_f, ~cnt_t);
        check(tok == expect_next, req_val, tok, expect_next);
        for (int i = 0; i < int'(hold_n); i++) begin
            @(negedge clk);
            check(cnt_t == tok && cnt_f == ~tok, "R6 held until ack", cnt_t, tok);
        end
        cnt_ack = 1'b1;
        w = 0;
        while (!is_null(cnt_t, cnt_f) && w < WAIT_MAX) begin
            @(negedge clk);
            w++;
            if (!is_null(cnt_t, cnt_f) && !(cnt_t == tok && cnt_f == ~tok)) begin
                check(1'b0, "R5 null between tokens", cnt_t, tok);
            end
        end
        check(w < WAIT_MAX, "R5 output returns to null", cnt_t | cnt_f, '0);
        for (int i = 0; i < int'(gap_n); i++) begin
            @(negedge clk);
            check(is_null(cnt_t, cnt_f), "R7 null while ack high", cnt_t | cnt_f, '0);
        end
        cnt_ack = 1'b0;
        expect_next = tok + 1'b1;
    endtask

    task automatic t_reset;
        rst_n   = 1'b0;
        cnt_ack = 1'b0;
        repeat (3) @(negedge clk);
        check(is_null(cnt_t, cnt_f), "R1 null in reset", cnt_t | cnt_f, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(is_null(cnt_t, cnt_f), "R1 null after reset", cnt_t | cnt_f, '0);
    endtask

    task automatic t_first_token;
        expect_next = 1;
        take_token(0, 0, "R3 first token is preload plus one");
    endtask

    task automatic t_long_hold;
        take_token(40, 0, "R4 count after long hold");
    endtask

    task automatic t_long_gap;
        take_token(0, 40, "R4 count after long null phase");
    endtask

    task automatic t_full_lap;
        for (int k = 0; k < (1 << W) + 3; k++) begin
            take_token($urandom_range(0, 3), $urandom_range(0, 3), "R4 count plus one");
        end
    endtask

    task automatic t_wrap_seen;
        // After the lap, the count must have passed all-ones and wrapped.
        take_token(1, 1, "R4 count after wrap");
    endtask

    initial begin
        n_checks = 0;
        n_fail   = 0;
        rst_n    = 1'b0;
        cnt_ack  = 1'b0;
        expect_next = 1;
        t_reset();
        t_first_token();
        t_long_hold();
        t_long_gap();
        t_full_lap();
        t_wrap_seen();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule